// File: doc/BRIEF.md
# DDR ADC Sample Word Assembler

This block sits behind the receive pins of a 14-bit analog-to-digital converter and rebuilds complete parallel samples from its output bus. In the double-data-rate arrangement the converter sends each sample over seven lanes, two bits per lane per period of its forwarded output clock. The block registers every lane on the rising edge and again on the falling edge of that clock. It then interleaves the two halves by bit position into one 14-bit word. The word leaves on a rising edge of the same clock, together with a valid strobe.

A second arrangement is chosen by a mode pin. In this single-data-rate mode all fourteen lines carry sample bits at once and are registered on the rising edge only. The mode pin is read only while reset is held, so a change of mode always goes through a reset. Samples are passed through as raw unsigned codes. Any sign or offset conversion belongs to a later stage. Input buffering and delay tuning sit outside the block.

Top module: `ddr_sample_assembler`

## Requirements
- R1: While reset is high, and at the first rising edge after it falls, valid_o is 0 and word_o is 0. Whenever valid_o is 0, word_o is 0.
- R2: mode_i is sampled only on rising edges with reset high (0 selects double-data-rate, 1 selects single-data-rate). Changes of mode_i while reset is low have no effect on the output.
- R3: In double-data-rate mode, the value on lanes_i[k] at a rising edge becomes bit 2k of the sample (k = 0..6).
- R4: In double-data-rate mode, the value on lanes_i[k] at a falling edge becomes bit 2k+1 of the sample.
- R5: The even bits taken at a rising edge are joined with the odd bits taken at the falling edge that follows it, never the one before it.
- R6: A sample whose first rising edge is edge n appears on word_o, with valid_o high, right after rising edge n+1. This holds in both modes.
- R7: After reset is released, valid_o stays low until the first complete sample is presented. The first rising edge with reset low starts the first sample.
- R8: In double-data-rate mode, lanes_i[13:7] are ignored.
- R9: In single-data-rate mode, word_o equals the full 14-bit value of lanes_i taken at a rising edge. Changes between rising edges are ignored.
- R10: Once valid_o rises it stays high every cycle, one new raw unsigned sample per clock period, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output clock forwarded by the converter; both edges are used |
| rst_i | input | 1 | Active-high synchronous reset; mode_i is captured while it is high |
| mode_i | input | 1 | 0 = double-data-rate on 7 lanes, 1 = single-data-rate on 14 lines |
| lanes_i | input | 14 | Converter data lines; bits 6:0 are the lanes in double-data-rate mode |
| word_o | output | 14 | Assembled unsigned sample |
| valid_o | output | 1 | High when word_o holds a sample |

## Verification
The bench drives even bits before each rising edge and odd bits before each falling edge. It checks every output word against a bench reference, so a design that swaps even and odd bits, or joins a rising half to the previous falling half, returns scrambled words. It uses all-ones, alternating and single-bit samples, which show a lane placed at the wrong bit position. It toggles mode_i outside reset and puts noise on the upper lines in double-data-rate mode, so a design that rereads the mode or uses unused lines corrupts its output. It checks the exact cycle of the first valid after each reset. It also puts noise on all lines during the falling half in single-data-rate mode, which catches a design that samples on the wrong edge.

// File: rtl/ddr_asm_pkg.sv
package ddr_asm_pkg;
    typedef enum logic {
        MODE_DDR = 1'b0,
        MODE_SDR = 1'b1
    } asm_mode_e;
endpackage

// File: rtl/ddr_rise_stage.sv
module ddr_rise_stage
    import ddr_asm_pkg::*;
#(
    parameter int LANES = 7
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 mode_i,
    input  logic [2*LANES-1:0]   lanes_i,
    output logic [2*LANES-1:0]   cap_o,
    output asm_mode_e            mode_o,
    output logic                 armed_o
);
    localparam int W = 2 * LANES;

    typedef struct packed {
        logic [W-1:0] cap;
        asm_mode_e    mode;
        logic         armed;
    } rise_st_t;

    rise_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.cap   = '0;
            st_d.mode  = asm_mode_e'(mode_i);
            st_d.armed = 1'b0;
        end else begin
            st_d.cap   = lanes_i;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cap_o   = st_q.cap;
    assign mode_o  = st_q.mode;
    assign armed_o = st_q.armed;

    AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> $stable(st_q.mode)); // R2
endmodule

// File: rtl/ddr_fall_stage.sv
module ddr_fall_stage #(
    parameter int LANES = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              armed_i,
    input  logic [LANES-1:0]  rise_cap_i,
    input  logic [LANES-1:0]  lanes_i,
    output logic [LANES-1:0]  even_o,
    output logic [LANES-1:0]  odd_o,
    output logic              pair_ok_o
);
    typedef struct packed {
        logic [LANES-1:0] even;
        logic [LANES-1:0] odd;
        logic             pair_ok;
    } fall_st_t;

    fall_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.even    = '0;
            st_d.odd     = '0;
            st_d.pair_ok = 1'b0;
        end else begin
            st_d.even    = rise_cap_i;
            st_d.odd     = lanes_i;
            st_d.pair_ok = armed_i;
        end
    end

    always_ff @(negedge clk_i) begin
        st_q <= st_d;
    end

    assign even_o    = st_q.even;
    assign odd_o     = st_q.odd;
    assign pair_ok_o = st_q.pair_ok;
endmodule

// File: rtl/ddr_word_merge.sv
module ddr_word_merge
    import ddr_asm_pkg::*;
#(
    parameter int LANES = 7
) (
    input  asm_mode_e           mode_i,
    input  logic [LANES-1:0]    even_i,
    input  logic [LANES-1:0]    odd_i,
    input  logic [2*LANES-1:0]  sdr_i,
    output logic [2*LANES-1:0]  word_o
);
    localparam int W = 2 * LANES;

    logic [W-1:0] ddr_word;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign ddr_word[2*k]   = even_i[k];
        assign ddr_word[2*k+1] = odd_i[k];
    end

    always_comb begin
        word_o = (mode_i == MODE_SDR) ? sdr_i : ddr_word;
    end
endmodule

// File: rtl/ddr_sample_assembler.sv
module ddr_sample_assembler
    import ddr_asm_pkg::*;
#(
    parameter int LANES = 7
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                mode_i,
    input  logic [2*LANES-1:0]  lanes_i,
    output logic [2*LANES-1:0]  word_o,
    output logic                valid_o
);
    localparam int W = 2 * LANES;

    logic [W-1:0]     rise_cap;
    asm_mode_e        mode_q;
    logic             armed;
    logic [LANES-1:0] even_h;
    logic [LANES-1:0] odd_h;
    logic             pair_ok;
    logic [W-1:0]     merged;

    ddr_rise_stage #(.LANES(LANES)) u_rise (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .mode_i  (mode_i),
        .lanes_i (lanes_i),
        .cap_o   (rise_cap),
        .mode_o  (mode_q),
        .armed_o (armed)
    );

    ddr_fall_stage #(.LANES(LANES)) u_fall (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .armed_i    (armed),
        .rise_cap_i (rise_cap[LANES-1:0]),
        .lanes_i    (lanes_i[LANES-1:0]),
        .even_o     (even_h),
        .odd_o      (odd_h),
        .pair_ok_o  (pair_ok)
    );

    ddr_word_merge #(.LANES(LANES)) u_merge (
        .mode_i (mode_q),
        .even_i (even_h),
        .odd_i  (odd_h),
        .sdr_i  (rise_cap),
        .word_o (merged)
    );

    typedef struct packed {
        logic [W-1:0] word;
        logic         valid;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (rst_i) begin
            out_d.word  = '0;
            out_d.valid = 1'b0;
        end else begin
            out_d.valid = (mode_q == MODE_SDR) ? armed : pair_ok;
            out_d.word  = out_d.valid ? merged : '0;
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    assign word_o  = out_q.word;
    assign valid_o = out_q.valid;

    logic [LANES-1:0] even_view;
    for (genvar k = 0; k < LANES; k++) begin : g_view
        assign even_view[k] = word_o[2*k];
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!valid_o && word_o == '0)); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> word_o == '0); // R1
    AST_DDR_EVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && mode_q == MODE_DDR) |-> even_view == $past(lanes_i[LANES-1:0], 2)); // R3
    AST_SDR_WORD: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && mode_q == MODE_SDR) |-> word_o == $past(lanes_i, 2)); // R9
    AST_VALID_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> valid_o); // R10
endmodule

// File: tb/ddr_sample_assembler_tb.sv
module ddr_sample_assembler_tb;
    localparam int LANES = 7;
    localparam int W = 2 * LANES;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode = 1'b0;
    logic [W-1:0] lanes = '0;
    logic [W-1:0] word;
    logic         valid;

    int total = 0;
    int bad = 0;
    logic [W-1:0] smp [0:63];

    always #2 clk = ~clk;

    ddr_sample_assembler #(.LANES(LANES)) u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .mode_i  (mode),
        .lanes_i (lanes),
        .word_o  (word),
        .valid_o (valid)
    );

    function automatic logic [LANES-1:0] even_of(input logic [W-1:0] s);
        logic [LANES-1:0] r;
        for (int k = 0; k < LANES; k++) r[k] = s[2*k];
        return r;
    endfunction

    function automatic logic [LANES-1:0] odd_of(input logic [W-1:0] s);
        logic [LANES-1:0] r;
        for (int k = 0; k < LANES; k++) r[k] = s[2*k+1];
        return r;
    endfunction

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got valid/word=%h expected %h", req, act, exp);
        end
    endtask

    task automatic run_phase(input logic md, input int n, input bit wiggle_mode);
        rst = 1'b1;
        mode = md;
        repeat (3) @(posedge clk);
        #1 chk("R1 reset hold", {valid, word}, '0);
        @(negedge clk);
        #1;
        rst = 1'b0;
        if (wiggle_mode) mode = ~md;
        if (md) lanes = smp[0];
        else lanes = {7'($urandom), even_of(smp[0])};
        for (int i = 0; i <= n; i++) begin
            @(posedge clk);
            #1;
            if (i == 0) chk("R7 first edge no valid", {valid, word}, '0);
            else chk(md ? "R6 R9 sdr word" : "R3 R4 R5 R6 ddr word",
                     {valid, word}, {1'b1, smp[i-1]});
            if (wiggle_mode) mode = 1'($urandom);
            if (md) lanes = W'($urandom);
            else lanes = {7'($urandom), odd_of(smp[i])};
            @(negedge clk);
            #1;
            if (md) lanes = smp[i+1];
            else lanes = {7'($urandom), even_of(smp[i+1])};
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0A1B));
        smp[0] = 14'h0000; smp[1] = 14'h3FFF; smp[2] = 14'h2AAA; smp[3] = 14'h1555;
        smp[4] = 14'h0001; smp[5] = 14'h2000; smp[6] = 14'h0002; smp[7] = 14'h1000;
        for (int i = 8; i < 64; i++) smp[i] = W'($urandom);
        // R8 R2: upper lanes noisy, mode_i toggled outside reset
        run_phase(1'b0, 50, 1'b1);
        for (int i = 8; i < 64; i++) smp[i] = W'($urandom);
        // R9: single-data-rate, noise during falling half
        run_phase(1'b1, 50, 1'b1);
        for (int i = 8; i < 64; i++) smp[i] = W'($urandom);
        // R2: back to double-data-rate through reset, R10 continuous valid
        run_phase(1'b0, 40, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        #1 chk("R1 mid-run reset", {valid, word}, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule